// File: doc/BRIEF.md
# Saturating Arithmetic Unit With Sticky Flag

This block performs 32-bit integer arithmetic that clamps instead of wrapping. It offers signed and unsigned saturating add and subtract, and clamping of a value to a chosen bit position in signed or unsigned form. The clamping also comes in a two-lane form that treats each 16-bit half separately. A further operation adds the operands with normal wraparound and only reports signed overflow. The result is combinational and follows the operation code, the two operands and the position input within the same cycle.

Every issued operation that clamps or overflows sets a cumulative flag. The flag stays set across later operations until a synchronous clear input drops it. A processor datapath uses the flag to learn that at least one operation in a sequence lost precision. Calculations without an issue strobe produce a result but leave the flag as it is.

Top module: `sat_alu`

## Requirements
- R1: While `rst_n` is low the flag `sat_flag` is forced to 0, and it reads 0 on the first cycle after reset is released.
- R2: Code 0 (signed add). If the operands have equal signs and the raw sum's sign differs from `opnd_a`, the result is 0x7FFFFFFF when `opnd_a` is non-negative and 0x80000000 otherwise, and the operation counts as saturating. In all other cases the result is the wrapped sum.
- R3: Code 1 (signed subtract). If the operand signs differ and the raw difference's sign differs from `opnd_a`, the result clamps as in R2 and the operation counts as saturating. In all other cases the result is the wrapped difference.
- R4: Code 2 (unsigned add). If the wrapped sum is below `opnd_a`, the result is 0xFFFFFFFF and the operation counts as saturating. Otherwise the result is the sum.
- R5: Code 3 (unsigned subtract). If the wrapped difference is above `opnd_a`, the result is 0 and the operation counts as saturating. Otherwise the result is the difference.
- R6: Code 8 (add with overflow flag). The result is always the wrapped sum, and the operation counts as saturating exactly when the signed overflow of R2 occurs.
- R7: Code 4 (signed clamp of `opnd_a` to position n = `sat_pos`). If `opnd_a` >> n (arithmetic shift) is positive, the result is 2^n-1. If it is below -1, the result is the bitwise complement of 2^n-1. Either case counts as saturating. Otherwise `opnd_a` passes through unchanged.
- R8: Code 5 (unsigned clamp to position n). A negative `opnd_a` gives 0 and a value above 2^n-1 gives 2^n-1, and either case counts as saturating. Otherwise `opnd_a` passes through unchanged.
- R9: Codes 6 and 7 apply R7 and R8, respectively, to each sign-extended 16-bit half of `opnd_a` independently. Each half's low 16 result bits go into the same half of `result`. The operation counts as saturating if either half clamps.
- R10: The cycle after a saturating operation is issued (`op_issue` high at a clock edge), `sat_flag` reads 1. The flag then holds 1 until a clear. An operation without `op_issue` never changes the flag.
- R11: `flag_clr` high at a clock edge clears the flag on the next cycle. An issued saturating operation in the same cycle takes precedence, and the flag stays 1.
- R12: Codes 9 to 15 give a result of 0 and never set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_issue | input | 1 | Operation is issued; qualifies flag update |
| op_code | input | 4 | Operation select |
| opnd_a | input | 32 | First operand, and the value to clamp |
| opnd_b | input | 32 | Second operand |
| sat_pos | input | 5 | Clamp bit position n |
| flag_clr | input | 1 | Synchronous clear of the sticky flag |
| result | output | 32 | Combinational result |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
The add and subtract paths are driven with the extreme operands 0, 1, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF. These separate an exact boundary that must not saturate from one step past it that must, and separate the positive clamp from the negative clamp. The clamp operations are tried at positions 0, 15, 16 and 31 and at random positions. Those points show whether the mask and the shift agree, and the dual-lane cases place a clamping value in one half only, which shows that the halves are independent. Random mixes of issued and unissued operations, with clears placed alongside them, test flag accumulation, the issue qualification and the precedence of a set over a clear.

// File: rtl/sat_alu_pkg.sv
package sat_alu_pkg;
   typedef enum logic [3:0] {
      OPC_SADD    = 4'd0,
      OPC_SSUB    = 4'd1,
      OPC_UADD    = 4'd2,
      OPC_USUB    = 4'd3,
      OPC_SCLAMP  = 4'd4,
      OPC_UCLAMP  = 4'd5,
      OPC_SCLAMP2 = 4'd6,
      OPC_UCLAMP2 = 4'd7,
      OPC_ADDV    = 4'd8
   } sat_op_e;
endpackage

// File: rtl/sat_addsub.sv
// Add/subtract with signed or unsigned clamping, or wrap-and-report.
module sat_addsub #(
   parameter int DW = 32
) (
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   input  logic          do_sub,
   input  logic          is_uns,
   input  logic          wrap_only,
   output logic [DW-1:0] y,
   output logic          ovf
);
   localparam int M = DW - 1;

   logic [DW-1:0] raw, clampv;
   logic          s_ovf, u_ovf;

   always_comb begin
      raw   = do_sub ? (a - b) : (a + b);
      s_ovf = do_sub ? ((a[M] ^ b[M]) & (raw[M] ^ a[M]))
                     : (~(a[M] ^ b[M]) & (raw[M] ^ a[M]));
      u_ovf = do_sub ? (raw > a) : (raw < a);
      ovf   = is_uns ? u_ovf : s_ovf;
      if (is_uns)
         clampv = do_sub ? '0 : '1;
      else
         clampv = a[M] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
      y = (ovf && !wrap_only) ? clampv : raw;
   end
endmodule

// File: rtl/sat_clamp.sv
// Clamp a value to bit position pos, signed or unsigned.
module sat_clamp #(
   parameter int DW = 32,
   parameter int PW = 5
) (
   input  logic [DW-1:0] val,
   input  logic [PW-1:0] pos,
   input  logic          is_uns,
   output logic [DW-1:0] y,
   output logic          hit
);
   localparam int M = DW - 1;
   localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

   logic [DW-1:0] top, mask;
   logic          s_hi, s_lo, u_neg, u_big;

   always_comb begin
      top   = $signed(val) >>> pos;
      mask  = (ONE << pos) - ONE;
      s_hi  = ~top[M] & (|top);
      s_lo  = top[M] & ~(&top);
      u_neg = val[M];
      u_big = ~val[M] & (val > mask);
      if (is_uns) begin
         hit = u_neg | u_big;
         y   = u_neg ? '0 : (u_big ? mask : val);
      end else begin
         hit = s_hi | s_lo;
         y   = s_hi ? mask : (s_lo ? ~mask : val);
      end
   end
endmodule

// File: rtl/sat_sticky.sv
// Cumulative flag: set wins over clear.
module sat_sticky (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic flag
);
   always_ff @(posedge clk) begin
      if (!rst_n)   flag <= 1'b0;
      else if (set) flag <= 1'b1;
      else if (clr) flag <= 1'b0;
   end
endmodule

// File: rtl/sat_alu.sv
module sat_alu
   import sat_alu_pkg::*;
#(
   parameter int DW = 32,
   parameter int PW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          op_issue,
   input  logic [3:0]    op_code,
   input  logic [DW-1:0] opnd_a,
   input  logic [DW-1:0] opnd_b,
   input  logic [PW-1:0] sat_pos,
   input  logic          flag_clr,
   output logic [DW-1:0] result,
   output logic          sat_flag
);
   localparam int HW    = DW / 2;
   localparam int LANES = 2;

   if (DW < 4 || (DW % 2) != 0) begin : g_bad_width
      $error("sat_alu: DW must be even and at least 4");
   end
   if ((1 << PW) != DW) begin : g_bad_pos
      $error("sat_alu: PW must equal log2(DW)");
   end

   sat_op_e       opc;
   logic [DW-1:0] as_y, full_y;
   logic          as_ovf, full_hit, sat_any;
   logic [DW-1:0] lane_y [LANES];
   logic [LANES-1:0] lane_hit;
   logic          clamp_uns, pair_uns;

   assign opc       = sat_op_e'(op_code);
   assign clamp_uns = (opc == OPC_UCLAMP);
   assign pair_uns  = (opc == OPC_UCLAMP2);

   sat_addsub #(.DW(DW)) u_addsub (
      .a         (opnd_a),
      .b         (opnd_b),
      .do_sub    (opc == OPC_SSUB || opc == OPC_USUB),
      .is_uns    (opc == OPC_UADD || opc == OPC_USUB),
      .wrap_only (opc == OPC_ADDV),
      .y         (as_y),
      .ovf       (as_ovf)
   );

   sat_clamp #(.DW(DW), .PW(PW)) u_full (
      .val    (opnd_a),
      .pos    (sat_pos),
      .is_uns (clamp_uns),
      .y      (full_y),
      .hit    (full_hit)
   );

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic [DW-1:0] sx;
      assign sx = {{HW{opnd_a[k*HW+HW-1]}}, opnd_a[k*HW +: HW]};
      sat_clamp #(.DW(DW), .PW(PW)) u_half (
         .val    (sx),
         .pos    (sat_pos),
         .is_uns (pair_uns),
         .y      (lane_y[k]),
         .hit    (lane_hit[k])
      );
   end

   always_comb begin
      result  = '0;
      sat_any = 1'b0;
      case (opc)
         OPC_SADD, OPC_SSUB, OPC_UADD, OPC_USUB, OPC_ADDV: begin
            result  = as_y;
            sat_any = as_ovf;
         end
         OPC_SCLAMP, OPC_UCLAMP: begin
            result  = full_y;
            sat_any = full_hit;
         end
         OPC_SCLAMP2, OPC_UCLAMP2: begin
            result  = {lane_y[1][HW-1:0], lane_y[0][HW-1:0]};
            sat_any = |lane_hit;
         end
         default: begin
            result  = '0;
            sat_any = 1'b0;
         end
      endcase
   end

   sat_sticky u_sticky (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (op_issue & sat_any),
      .clr   (flag_clr),
      .flag  (sat_flag)
   );
endmodule

// File: rtl/sat_alu_chk.sv
module sat_alu_chk #(
   parameter int DW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          op_issue,
   input logic [3:0]    op_code,
   input logic [DW-1:0] opnd_a,
   input logic [DW-1:0] opnd_b,
   input logic          flag_clr,
   input logic [DW-1:0] result,
   input logic          sat_flag,
   input logic          sat_any
);
   assert_flag_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (op_issue && sat_any) |=> sat_flag);

   assert_flag_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (sat_flag && !flag_clr) |=> sat_flag);

   assert_flag_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!sat_flag && !(op_issue && sat_any)) |=> !sat_flag);

   assert_flag_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr && !(op_issue && sat_any)) |=> !sat_flag);

   assert_wrap_sum_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (op_code == 4'd8) |-> (result == opnd_a + opnd_b));

   assert_uadd_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (op_code == 4'd2 && sat_any) |-> (&result));

   assert_unused_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (op_code > 4'd8) |-> (result == '0 && !sat_any));
endmodule

bind sat_alu sat_alu_chk #(.DW(DW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .op_issue (op_issue),
   .op_code  (op_code),
   .opnd_a   (opnd_a),
   .opnd_b   (opnd_b),
   .flag_clr (flag_clr),
   .result   (result),
   .sat_flag (sat_flag),
   .sat_any  (sat_any)
);

// File: tb/sat_alu_tb_top.sv
`timescale 1ns/1ps
module sat_alu_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        op_issue;
   logic [3:0]  op_code;
   logic [31:0] opnd_a, opnd_b;
   logic [4:0]  sat_pos;
   logic        flag_clr;
   logic [31:0] result;
   logic        sat_flag;

   int  n_run = 0;
   int  n_fail = 0;
   bit  model_flag = 1'b0;
   bit  done = 1'b0;

   always #4 clk = ~clk;

   sat_alu dut_i (
      .clk(clk), .rst_n(rst_n), .op_issue(op_issue), .op_code(op_code),
      .opnd_a(opnd_a), .opnd_b(opnd_b), .sat_pos(sat_pos),
      .flag_clr(flag_clr), .result(result), .sat_flag(sat_flag)
   );

   function automatic longint clamp_s(longint v, int n, output bit s);
      longint lim = (64'sd1 <<< n) - 1;
      s = 1'b0;
      if (v > lim) begin s = 1'b1; return lim; end
      if (v < -(lim + 1)) begin s = 1'b1; return -(lim + 1); end
      return v;
   endfunction

   function automatic longint clamp_u(longint v, int n, output bit s);
      longint lim = (64'sd1 <<< n) - 1;
      s = 1'b0;
      if (v < 0) begin s = 1'b1; return 0; end
      if (v > lim) begin s = 1'b1; return lim; end
      return v;
   endfunction

   function automatic logic [31:0] ref_op(int op, logic [31:0] a, logic [31:0] b,
                                          int n, output bit s);
      longint sa = longint'($signed(a));
      longint sb = longint'($signed(b));
      longint ua = longint'({32'd0, a});
      longint ub = longint'({32'd0, b});
      longint t, lo, hi;
      bit s0, s1;
      s = 1'b0;
      case (op)
         0, 1: begin
            t = (op == 0) ? sa + sb : sa - sb;
            if (t > 64'sd2147483647)  begin s = 1'b1; return 32'h7FFFFFFF; end
            if (t < -64'sd2147483648) begin s = 1'b1; return 32'h80000000; end
            return t[31:0];
         end
         2: begin
            t = ua + ub;
            if (t > 64'sd4294967295) begin s = 1'b1; return 32'hFFFFFFFF; end
            return t[31:0];
         end
         3: begin
            t = ua - ub;
            if (t < 0) begin s = 1'b1; return 32'd0; end
            return t[31:0];
         end
         4: begin t = clamp_s(sa, n, s); return t[31:0]; end
         5: begin t = clamp_u(sa, n, s); return t[31:0]; end
         6, 7: begin
            lo = longint'($signed(a[15:0]));
            hi = longint'($signed(a[31:16]));
            if (op == 6) begin lo = clamp_s(lo, n, s0); hi = clamp_s(hi, n, s1); end
            else         begin lo = clamp_u(lo, n, s0); hi = clamp_u(hi, n, s1); end
            s = s0 | s1;
            return {hi[15:0], lo[15:0]};
         end
         8: begin
            t = sa + sb;
            s = (t > 64'sd2147483647) || (t < -64'sd2147483648);
            return a + b;
         end
         default: return 32'd0;
      endcase
   endfunction

   function automatic string req_of(int op);
      case (op)
         0: return "R2";
         1: return "R3";
         2: return "R4";
         3: return "R5";
         4: return "R7";
         5: return "R8";
         6, 7: return "R9";
         8: return "R6";
         default: return "R12";
      endcase
   endfunction

   task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Called just after a falling edge; returns just after the next falling edge.
   task automatic do_op(int op, logic [31:0] a, logic [31:0] b, int n,
                        bit issue, bit clr, string ftag);
      logic [31:0] exp;
      bit s;
      op_code = op[3:0]; opnd_a = a; opnd_b = b; sat_pos = n[4:0];
      op_issue = issue; flag_clr = clr;
      exp = ref_op(op, a, b, n, s);
      #1;
      check(result === exp, req_of(op), result, exp);
      if (issue && s) model_flag = 1'b1;
      else if (clr)   model_flag = 1'b0;
      @(negedge clk);
      #1;
      check(sat_flag === model_flag, ftag, {31'd0, sat_flag}, {31'd0, model_flag});
      op_issue = 1'b0; flag_clr = 1'b0;
   endtask

   function automatic logic [31:0] pick_val();
      case ($urandom_range(0, 7))
         0: return 32'd0;
         1: return 32'd1;
         2: return 32'h7FFFFFFF;
         3: return 32'h80000000;
         4: return 32'hFFFFFFFF;
         5: return {16'($urandom), 16'h8000 ^ 16'($urandom_range(0, 3))};
         default: return $urandom;
      endcase
   endfunction

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      rst_n = 1'b0; op_issue = 1'b0; op_code = 4'd0; opnd_a = '0; opnd_b = '0;
      sat_pos = '0; flag_clr = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      check(sat_flag === 1'b0, "R1", {31'd0, sat_flag}, 32'd0);

      // Saturating op without issue leaves flag alone (R10)
      do_op(0, 32'h7FFFFFFF, 32'd1, 0, 1'b0, 1'b0, "R10");
      // Boundary: exactly max, no saturation (R2)
      do_op(0, 32'h7FFFFFFE, 32'd1, 0, 1'b1, 1'b0, "R10");
      do_op(0, 32'h80000000, 32'hFFFFFFFF, 0, 1'b1, 1'b0, "R10");
      do_op(1, 32'h80000000, 32'd1, 0, 1'b1, 1'b0, "R10");
      do_op(1, 32'h7FFFFFFF, 32'hFFFFFFFF, 0, 1'b1, 1'b0, "R10");
      // Clear alone (R11)
      do_op(4'd9, 32'd5, 32'd5, 0, 1'b1, 1'b1, "R11");
      do_op(2, 32'hFFFFFFFF, 32'd0, 0, 1'b1, 1'b0, "R10");
      do_op(2, 32'hFFFFFFFF, 32'd1, 0, 1'b1, 1'b0, "R10");
      // Set and clear same cycle: set wins (R11)
      do_op(3, 32'd3, 32'd4, 0, 1'b1, 1'b1, "R11");
      do_op(3, 32'd4, 32'd4, 0, 1'b1, 1'b1, "R11");
      do_op(8, 32'h7FFFFFFF, 32'd1, 0, 1'b1, 1'b0, "R10");
      do_op(4'd15, 32'hFFFFFFFF, 32'hFFFFFFFF, 31, 1'b1, 1'b1, "R11");
      do_op(4, 32'd200, 32'd0, 7, 1'b1, 1'b0, "R10");
      do_op(4, 32'hFFFFFF00, 32'd0, 0, 1'b1, 1'b1, "R11");
      do_op(4, 32'h80000000, 32'd0, 31, 1'b1, 1'b0, "R10");
      do_op(5, 32'hFFFFFFFF, 32'd0, 8, 1'b1, 1'b1, "R11");
      do_op(5, 32'h7FFFFFFF, 32'd0, 31, 1'b1, 1'b0, "R10");
      // Only the upper lane clamps (R9)
      do_op(6, 32'h7FFF0012, 32'd0, 8, 1'b1, 1'b1, "R11");
      do_op(7, 32'h0012FFFF, 32'd0, 15, 1'b1, 1'b1, "R11");
      do_op(7, 32'h00120034, 32'd0, 16, 1'b1, 1'b1, "R11");

      for (int i = 0; i < 4000; i++) begin
         int op = (i % 5 == 0) ? $urandom_range(0, 15) : $urandom_range(0, 8);
         do_op(op, pick_val(), pick_val(), $urandom_range(0, 31),
               1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 5) == 0), "R10");
      end

      // Reset clears a set flag (R1)
      do_op(0, 32'h7FFFFFFF, 32'h7FFFFFFF, 0, 1'b1, 1'b0, "R10");
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1; model_flag = 1'b0;
      #1;
      check(sat_flag === 1'b0, "R1", {31'd0, sat_flag}, 32'd0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule